// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes in byte frames from a keyboard over two wires that the keyboard drives: a clock line and a data line. Both lines are brought into the system clock domain through two-flop synchronizers. The clock line is also passed through a glitch filter, and the receiver acts on rising edges of the filtered keyboard clock. A frame has a low start bit, then eight data bits sent least-significant first, then a parity bit chosen so that the data bits and the parity bit together hold an odd number of ones. After the parity bit the keyboard drives data low as the stop condition.

Each byte that arrives with correct framing and parity is written into a small receive FIFO. The FIFO has a ready/valid read port and a sticky overflow flag. A framing error, a parity error or a stall in the middle of a frame produces a one-cycle resend request carrying code 0xFE, and the receiver goes back to idle. Sending that code back to the keyboard is left to other logic. A host-side inhibit input asks for the data line to be held low, which blocks the keyboard from sending. While inhibit is active the receiver ignores the line.

Top module: `kbd_frame_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_valid_o=0, rd_data_o=0xFF, resend_o=0, resend_code_o=0x00, timeout_o=0, overflow_o=0 and kb_dat_pull_o=0.
- R2: A frame is received on ten rising edges of the filtered keyboard clock, with the data line sampled at each edge. The first edge must see 0 (start bit). The next eight edges give data bits 0 to 7, least-significant first. The tenth edge gives the parity bit. A frame whose nine data and parity bits hold an odd number of ones is pushed into the FIFO as one byte.
- R3: When the nine data and parity bits hold an even number of ones, no byte is stored and resend_o pulses for exactly one cycle.
- R4: A rising edge in idle that samples data=1 is a framing error. It pulses resend_o, stores nothing, and leaves the receiver in idle, so that the next good frame is received correctly.
- R5: A low pulse on the keyboard clock shorter than FILT_LEN system cycles produces no edge.
- R6: When a frame has started and no rising edge arrives for TIMEOUT_CYC cycles, timeout_o and resend_o pulse together in the same cycle, nothing is stored, and the receiver returns to idle.
- R7: The FIFO holds up to DEPTH bytes and returns them oldest first. One byte is removed in each cycle where rd_valid_o=1 and rd_ready_i=1. A byte that arrives while the FIFO is full is accepted if a pop happens in that same cycle.
- R8: A byte that arrives while the FIFO is full and no pop happens is dropped, and overflow_o is set. Once set, overflow_o stays 1 until reset. The stored bytes are not changed.
- R9: When the FIFO is empty, rd_valid_o=0 and rd_data_o=0xFF.
- R10: kb_dat_pull_o equals inhibit_i delayed by one cycle. While it is 1, keyboard clock edges store no byte and raise no resend.
- R11: resend_code_o is 0xFE in every cycle where resend_o=1 and 0x00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| inhibit_i | input | 1 | Host request to block keyboard sending |
| kb_dat_pull_o | output | 1 | 1 = drive the data line low |
| rd_ready_i | input | 1 | Reader accepts the head byte |
| rd_valid_o | output | 1 | FIFO holds at least one byte |
| rd_data_o | output | DATA_W | Head byte, 0xFF when empty |
| resend_o | output | 1 | One-cycle resend request |
| resend_code_o | output | 8 | Resend command code (0xFE during request) |
| timeout_o | output | 1 | One-cycle mid-frame timeout flag |
| overflow_o | output | 1 | Sticky: a byte was lost to a full FIFO |

## Verification
The interesting coincidence is a reader pop that lands in the same cycle as a new byte being pushed into a full FIFO. The bench fills the FIFO, then sends a ninth frame. During the high phase of that frame's last keyboard clock pulse, it places a single-cycle pop at every offset in turn, starting from a fresh reset for each offset. Each run is judged by consistency. Either overflow is set and the seven remaining bytes come out in order, or overflow is clear and the eighth byte read back is the new one. Across the sweep, both outcomes must occur.

// File: rtl/kfr_pkg.sv
package kfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAR  = 2'd2
  } rx_state_t;

  localparam logic [7:0] RESEND_CODE = 8'hFE;
  localparam logic [7:0] EMPTY_BYTE  = 8'hFF;
endpackage

// File: rtl/kfr_line_cond.sv
// Synchronizes both keyboard lines and filters the clock line.
// The filtered clock only changes after FILT_LEN equal samples in a row.
module kfr_line_cond #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic kb_clk_i,
  input  logic kb_dat_i,
  output logic dat_s_o,
  output logic rise_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]   clk_sync;
  logic [SYNC_N-1:0]   dat_sync;
  logic [FILT_LEN-1:0] win;
  logic                filt_q;
  logic                filt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync <= '1;
      dat_sync <= '1;
      win      <= '1;
      filt_q   <= 1'b1;
      filt_d   <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[SYNC_N-2:0], kb_clk_i};
      dat_sync <= {dat_sync[SYNC_N-2:0], kb_dat_i};
      win      <= {win[FILT_LEN-2:0], clk_sync[SYNC_N-1]};
      if (&win)       filt_q <= 1'b1;
      else if (~|win) filt_q <= 1'b0;
      filt_d   <= filt_q;
    end
  end

  assign rise_o  = filt_q & ~filt_d;
  assign dat_s_o = dat_sync[SYNC_N-1];
endmodule

// File: rtl/kfr_frame_fsm.sv
// Frame walker: idle -> data bits -> parity -> idle.
// Also runs the mid-frame timeout counter.
module kfr_frame_fsm
  import kfr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              rise,
  input  logic              dat,
  output logic              push_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              resend_o,
  output logic              timeout_o
);
  localparam int BW = $clog2(DATA_W);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  rx_state_t         st;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              par;
  logic [TW-1:0]     gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_idx   <= '0;
      shreg     <= '0;
      par       <= 1'b0;
      gap_cnt   <= '0;
      push_o    <= 1'b0;
      rx_byte_o <= '0;
      resend_o  <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      push_o    <= 1'b0;
      resend_o  <= 1'b0;
      timeout_o <= 1'b0;
      if (hold) begin
        st      <= ST_IDLE;
        bit_idx <= '0;
        shreg   <= '0;
        par     <= 1'b0;
        gap_cnt <= '0;
      end else if (rise) begin
        gap_cnt <= '0;
        case (st)
          ST_IDLE: begin
            if (dat) resend_o <= 1'b1;   // start bit must be low
            else begin
              st      <= ST_DATA;
              bit_idx <= '0;
            end
          end
          ST_DATA: begin
            shreg   <= {dat, shreg[DATA_W-1:1]};
            par     <= par ^ dat;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == BW'(DATA_W - 1)) st <= ST_PAR;
          end
          default: begin
            if (par ^ dat) begin
              push_o    <= 1'b1;
              rx_byte_o <= shreg;
            end else begin
              resend_o  <= 1'b1;
            end
            st    <= ST_IDLE;
            shreg <= '0;
            par   <= 1'b0;
          end
        endcase
      end else if (st != ST_IDLE) begin
        if (gap_cnt == TW'(TIMEOUT_CYC - 1)) begin
          timeout_o <= 1'b1;
          resend_o  <= 1'b1;
          st        <= ST_IDLE;
          shreg     <= '0;
          par       <= 1'b0;
          gap_cnt   <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kfr_fifo.sv
// Receive FIFO: storage is not reset, ready/valid read, sticky overflow.
module kfr_fifo
  import kfr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp;
  logic [AW-1:0]     rp;
  logic [AW:0]       cnt;
  logic              full;
  logic              empty;
  logic              pop;
  logic              wr;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign pop   = rd_ready & ~empty;
  assign wr    = push & (~full | pop);

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr)  wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push & ~wr) overflow <= 1'b1;
    end
  end

  assign rd_valid = ~empty;
  assign rd_data  = empty ? DATA_W'(EMPTY_BYTE) : mem[rp];
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kfr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_clk_i,
  input  logic              kb_dat_i,
  input  logic              inhibit_i,
  output logic              kb_dat_pull_o,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              resend_o,
  output logic [7:0]        resend_code_o,
  output logic              timeout_o,
  output logic              overflow_o
);
  logic              inh_q;
  logic              dat_s;
  logic              rise;
  logic              push;
  logic [DATA_W-1:0] rx_byte;

  always_ff @(posedge clk) begin
    if (rst) inh_q <= 1'b0;
    else     inh_q <= inhibit_i;
  end
  assign kb_dat_pull_o = inh_q;

  kfr_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .kb_clk_i (kb_clk_i),
    .kb_dat_i (kb_dat_i),
    .dat_s_o  (dat_s),
    .rise_o   (rise)
  );

  kfr_frame_fsm #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .hold      (inh_q),
    .rise      (rise),
    .dat       (dat_s),
    .push_o    (push),
    .rx_byte_o (rx_byte),
    .resend_o  (resend_o),
    .timeout_o (timeout_o)
  );

  kfr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .din      (rx_byte),
    .rd_ready (rd_ready_i),
    .rd_valid (rd_valid_o),
    .rd_data  (rd_data_o),
    .overflow (overflow_o)
  );

  assign resend_code_o = resend_o ? RESEND_CODE : 8'h00;
endmodule

// File: rtl/kfr_checker.sv
module kfr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inhibit_i,
  input logic              kb_dat_pull_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              resend_o,
  input logic [7:0]        resend_code_o,
  input logic              timeout_o,
  input logic              overflow_o
);
  // R11
  p_code_on_r11: assert property (@(posedge clk) disable iff (rst)
    resend_o |-> resend_code_o == 8'hFE);
  p_code_off_r11: assert property (@(posedge clk) disable iff (rst)
    !resend_o |-> resend_code_o == 8'h00);
  // R3
  p_resend_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    resend_o |=> !resend_o);
  // R6
  p_timeout_resend_r6: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> resend_o);
  // R9
  p_empty_ff_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> rd_data_o == DATA_W'(8'hFF));
  // R8
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);
  // R10
  p_pull_on_r10: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |=> kb_dat_pull_o);
  p_pull_off_r10: assert property (@(posedge clk) disable iff (rst)
    !inhibit_i |=> !kb_dat_pull_o);
endmodule

bind kbd_frame_rx kfr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .inhibit_i     (inhibit_i),
  .kb_dat_pull_o (kb_dat_pull_o),
  .rd_valid_o    (rd_valid_o),
  .rd_data_o     (rd_data_o),
  .resend_o      (resend_o),
  .resend_code_o (resend_code_o),
  .timeout_o     (timeout_o),
  .overflow_o    (overflow_o)
);

// File: tb/tb_kbd_frame_rx.sv
`timescale 1ns/1ps
module tb_kbd_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 3;
  localparam int TMO  = 400;
  localparam int LO   = 6;
  localparam int HI   = 12;

  logic clk = 0, rst = 1;
  logic kb_clk_i = 1, kb_dat_i = 1, inhibit_i = 0, rd_ready_i = 0;
  logic kb_dat_pull_o, rd_valid_o, resend_o, timeout_o, overflow_o;
  logic [7:0] rd_data_o, resend_code_o;

  int n_chk = 0, n_bad = 0;
  int resend_cnt = 0, tmo_cnt = 0, code_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_frame_rx #(.DATA_W(8), .DEPTH(8), .FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
    .inhibit_i(inhibit_i), .kb_dat_pull_o(kb_dat_pull_o),
    .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .resend_o(resend_o), .resend_code_o(resend_code_o),
    .timeout_o(timeout_o), .overflow_o(overflow_o));

  always @(negedge clk) begin
    if (!rst) begin
      if (resend_o) resend_cnt++;
      if (timeout_o) tmo_cnt++;
      if (resend_o && resend_code_o !== 8'hFE) code_bad++;
      if (!resend_o && resend_code_o !== 8'h00) code_bad++;
      if (timeout_o && !resend_o) code_bad++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; kb_clk_i = 1; kb_dat_i = 1; inhibit_i = 0; rd_ready_i = 0;
    wait_cyc(5);
    rst = 0;
    wait_cyc(FILT + 4);
  endtask

  task automatic pulse_bit(input logic d);
    kb_clk_i = 0; kb_dat_i = d;
    wait_cyc(LO);
    kb_clk_i = 1;
    wait_cyc(HI);
  endtask

  // pop_at >= 0 places a one-cycle pop in the high phase of the parity pulse
  task automatic send_frame(input logic [7:0] b, input logic bad_par, input int pop_at,
                            output logic [7:0] popped);
    logic p;
    p = ~(^b) ^ bad_par;
    popped = 8'h00;
    pulse_bit(1'b0);
    for (int i = 0; i < 8; i++) pulse_bit(b[i]);
    kb_clk_i = 0; kb_dat_i = p;
    wait_cyc(LO);
    kb_clk_i = 1;
    for (int c = 0; c < HI; c++) begin
      rd_ready_i = (c == pop_at);
      if (c == pop_at) popped = rd_data_o;
      @(negedge clk);
    end
    rd_ready_i = 0;
    kb_dat_i = 0;
    wait_cyc(16);
    kb_dat_i = 1;
    wait_cyc(8);
  endtask

  task automatic send(input logic [7:0] b, input logic bad_par);
    logic [7:0] unused_pop;
    send_frame(b, bad_par, -1, unused_pop);
  endtask

  task automatic pop_one(output logic [7:0] d, output logic v);
    d = rd_data_o; v = rd_valid_o;
    rd_ready_i = 1;
    @(negedge clk);
    rd_ready_i = 0;
  endtask

  task automatic expect_byte(input string req, input logic [7:0] exp);
    logic [7:0] d; logic v;
    pop_one(d, v);
    chk({req, " valid"}, v, 1);
    chk({req, " data"}, d, exp);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    rst = 1; wait_cyc(3);
    chk("R1 valid", rd_valid_o, 0);
    chk("R1 data", rd_data_o, 8'hFF);
    chk("R1 resend", resend_o, 0);
    chk("R1 code", resend_code_o, 8'h00);
    chk("R1 timeout", timeout_o, 0);
    chk("R1 overflow", overflow_o, 0);
    chk("R1 pull", kb_dat_pull_o, 0);
    rst = 0;
    wait_cyc(1);
    chk("R1 valid after release", rd_valid_o, 0);
    chk("R1 overflow after release", overflow_o, 0);
    chk("R1 pull after release", kb_dat_pull_o, 0);
    wait_cyc(FILT + 4);
  endtask

  task automatic t_basic_r2();
    logic [7:0] pats [5] = '{8'hA5, 8'h00, 8'hFF, 8'h80, 8'h01};
    for (int i = 0; i < 5; i++) begin
      send(pats[i], 0);
      expect_byte("R2 byte", pats[i]);
    end
    chk("R2 no resend", resend_cnt, 0);
  endtask

  task automatic t_parity_r3();
    int r0 = resend_cnt;
    send(8'h3C, 1);
    chk("R3 resend count", resend_cnt, r0 + 1);
    chk("R3 nothing stored", rd_valid_o, 0);
    chk("R9 empty data", rd_data_o, 8'hFF);
  endtask

  task automatic t_start_r4();
    int r0 = resend_cnt;
    pulse_bit(1'b1);
    kb_dat_i = 1;
    wait_cyc(20);
    chk("R4 resend count", resend_cnt, r0 + 1);
    chk("R4 nothing stored", rd_valid_o, 0);
    send(8'h5A, 0);
    expect_byte("R4 recovery", 8'h5A);
  endtask

  task automatic t_glitch_r5();
    int r0 = resend_cnt;
    kb_dat_i = 1;
    kb_clk_i = 0; wait_cyc(FILT - 1);
    kb_clk_i = 1; wait_cyc(20);
    chk("R5 glitch no resend", resend_cnt, r0);
    chk("R5 glitch nothing stored", rd_valid_o, 0);
    send(8'h96, 0);
    expect_byte("R5 alignment kept", 8'h96);
  endtask

  task automatic t_timeout_r6();
    int r0 = resend_cnt, t0 = tmo_cnt;
    pulse_bit(1'b0);
    pulse_bit(1'b1); pulse_bit(1'b0); pulse_bit(1'b1);
    wait_cyc(TMO + 50);
    chk("R6 timeout count", tmo_cnt, t0 + 1);
    chk("R6 resend count", resend_cnt, r0 + 1);
    chk("R6 nothing stored", rd_valid_o, 0);
    kb_dat_i = 1;
    send(8'hC3, 0);
    expect_byte("R6 recovery", 8'hC3);
  endtask

  task automatic t_order_r7();
    for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), 0);
    chk("R7 overflow clear at full", overflow_o, 0);
    for (int i = 0; i < 8; i++) expect_byte("R7 order", 8'h10 + 8'(i));
    chk("R9 empty valid", rd_valid_o, 0);
    chk("R9 empty data", rd_data_o, 8'hFF);
  endtask

  task automatic t_overflow_r8();
    for (int i = 0; i < 8; i++) send(8'h20 + 8'(i), 0);
    send(8'h99, 0);
    chk("R8 overflow set", overflow_o, 1);
    for (int i = 0; i < 8; i++) expect_byte("R8 contents kept", 8'h20 + 8'(i));
    chk("R8 extra dropped", rd_valid_o, 0);
    wait_cyc(5);
    chk("R8 overflow sticky", overflow_o, 1);
    do_reset();
    chk("R8 cleared by reset", overflow_o, 0);
  endtask

  task automatic t_inhibit_r10();
    int r0 = resend_cnt;
    inhibit_i = 1;
    wait_cyc(2);
    chk("R10 pull on", kb_dat_pull_o, 1);
    send(8'h77, 0);
    pulse_bit(1'b1);
    wait_cyc(10);
    chk("R10 nothing stored", rd_valid_o, 0);
    chk("R10 no resend", resend_cnt, r0);
    inhibit_i = 0;
    wait_cyc(2);
    chk("R10 pull off", kb_dat_pull_o, 0);
    send(8'h77, 0);
    expect_byte("R10 after release", 8'h77);
  endtask

  task automatic t_sweep_r7_r8();
    bit seen_ovf = 0, seen_acc = 0;
    for (int off = 0; off < HI; off++) begin
      logic [7:0] popped, d; logic v;
      int n;
      logic ovf;
      logic [7:0] last;
      do_reset();
      for (int i = 0; i < 8; i++) send(8'h40 + 8'(i), 0);
      send_frame(8'hE7, 0, off, popped);
      chk("R7 sweep popped head", popped, 8'h40);
      ovf = overflow_o;
      n = 0; last = 8'h00;
      for (int k = 0; k < 9; k++) begin
        if (rd_valid_o) begin
          pop_one(d, v);
          if (n < 7) chk("R7 sweep order", d, 8'h41 + 8'(n));
          last = d;
          n++;
        end
      end
      if (ovf) begin
        seen_ovf = 1;
        chk("R8 sweep count on overflow", n, 7);
      end else begin
        seen_acc = 1;
        chk("R7 sweep count on accept", n, 8);
        chk("R7 sweep new byte last", last, 8'hE7);
      end
    end
    chk("R8 sweep saw overflow", seen_ovf, 1);
    chk("R7 sweep saw same-cycle accept", seen_acc, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    t_reset_r1();
    t_basic_r2();
    t_parity_r3();
    t_start_r4();
    t_glitch_r5();
    t_timeout_r6();
    t_order_r7();
    t_overflow_r8();
    t_inhibit_r10();
    t_sweep_r7_r8();
    chk("R11 resend code", code_bad, 0);
    summary();
  end
endmodule